// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Interrupt

This block controls how a small microcontroller system enters and leaves its low-power state. Firmware requests power-down by writing a control bit through a simple register write port. The block waits a fixed number of processor clock cycles, which gives firmware time to issue its stop instruction, and then raises a power-down output that switches off the analog circuits.

A rising edge on any wake input (timer alarm, key press, card event, bus activity) drops the request and the power-down output. The block then waits a second, longer interval so that the oscillator and PLL can settle. After that it raises a wake interrupt, which stays high until firmware acknowledges it. A select bit chooses what drives the processor's interrupt input: either this wake interrupt or a user pin, whose polarity comes from a source code.

The controller is a state machine with five states. IDLE goes to ENTRY on a request write. ENTRY goes to DOWN when the entry count ends, or back to IDLE (cancel) on a wake edge. DOWN goes to SETTLE on a wake edge. SETTLE goes to IRQ when the settle count ends. IRQ goes to IDLE on an acknowledge write.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, pd_req, pd_out and int0_out are low, the interrupt select is 0 and both delay counters are cleared.
- R2: A write to address 0 with data bit 7 set, made in IDLE, raises pd_req on that clock edge. pd_out rises on the 32nd rising edge after the write edge.
- R3: Wake inputs pass through a two-flop synchronizer and a rising-edge detector. In DOWN, an input that rises before edge e clears pd_req and pd_out on edge e+2.
- R4: The wake interrupt rises on the 512th rising edge after the edge that cleared pd_out. With select = 1 it appears on int0_out.
- R5: The wake interrupt stays high until a write to address 2 with data bit 0 set, which returns the block to IDLE. A write to address 2 with bit 0 clear has no effect.
- R6: A wake edge during ENTRY cancels entry: pd_req clears, pd_out never rises and no wake interrupt follows.
- R7: A wake edge in IDLE is ignored and raises no interrupt.
- R8: A wake input held high acts only once, on its rising edge. A later power-down entry with that input still high completes.
- R9: Data bit 7 written to address 1 sets the select. With select = 0, int0_out equals usr_pin when usr_src = 4, equals the inverse of usr_pin when usr_src = 6, and is low for any other code.
- R10: A power-down request written outside IDLE (during SETTLE or IRQ) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 interrupt select, 2 status acknowledge |
| wr_data | input | 8 | Write data |
| wake_in | input | NUM_WAKE | Asynchronous wake event inputs |
| usr_pin | input | 1 | User I/O pin level |
| usr_src | input | 3 | User pin interrupt source code |
| pd_req | output | 1 | Power-down control bit (ENTRY or DOWN) |
| pd_out | output | 1 | Power-down signal to the analog circuits |
| int0_out | output | 1 | Processor external interrupt 0 |

## Verification
The interrupt mux is tried with a table of select, source code and pin levels. The table tells the two polarity codes apart from each other and from the codes that must stay silent, and it shows that select = 1 hides the pin. The sequence is run end to end and sampled on the cycles just before and just after each expected edge, so that a delay that is off by one cycle shows up. A wake pulse in each of IDLE, ENTRY and DOWN tells cancellation, acceptance and the ignored case apart. A wake input held high across a later entry tells edge detection apart from level detection.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_DOWN,
        ST_SETTLE,
        ST_IRQ
    } pd_state_t;

    localparam int          ADDR_W    = 2;
    localparam logic [1:0]  ADDR_CTRL = 2'd0;
    localparam logic [1:0]  ADDR_MUX  = 2'd1;
    localparam logic [1:0]  ADDR_STAT = 2'd2;
    localparam int          REQ_BIT   = 7;
    localparam int          ACK_BIT   = 0;
    localparam logic [2:0]  SRC_HIGH  = 3'd4;
    localparam logic [2:0]  SRC_LOW   = 3'd6;
endpackage

// File: rtl/tc_counter.sv
module tc_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    output logic tc
);
    localparam int W = $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (ce)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tc = ce && (cnt == LAST);
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wake_in,
    output logic         wake_rise
);
    logic [N-1:0] meta_q, sync_q, prev_q, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= wake_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = sync_q[i] & ~prev_q[i];
    end

    assign wake_rise = |rise;
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
    import pwrdn_pkg::*;
#(
    parameter int ENTRY_CYC  = 32,
    parameter int SETTLE_CYC = 512,
    parameter int NUM_WAKE   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [NUM_WAKE-1:0] wake_in,
    input  logic                usr_pin,
    input  logic [2:0]          usr_src,
    output logic                pd_req,
    output logic                pd_out,
    output logic                int0_out
);
    pd_state_t state_q, state_d;
    logic      sel_q;
    logic      wake_rise, entry_tc, settle_tc;
    logic      req_wr, ack_wr, sel_wr;
    logic      wake_irq, usr_int;
    logic      unused_bits;

    assign unused_bits = ^wr_data[6:1];

    assign req_wr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[REQ_BIT];
    assign ack_wr = wr_en && (wr_addr == ADDR_STAT) && wr_data[ACK_BIT];
    assign sel_wr = wr_en && (wr_addr == ADDR_MUX);

    wake_edge #(.N(NUM_WAKE)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_in   (wake_in),
        .wake_rise (wake_rise)
    );

    tc_counter #(.LIMIT(ENTRY_CYC)) u_entry_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (state_q == ST_ENTRY),
        .clr   (state_q != ST_ENTRY),
        .tc    (entry_tc)
    );

    tc_counter #(.LIMIT(SETTLE_CYC)) u_settle_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (state_q == ST_SETTLE),
        .clr   (state_q != ST_SETTLE),
        .tc    (settle_tc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sel_wr)
                sel_q <= wr_data[REQ_BIT];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_wr)         state_d = ST_ENTRY;
            ST_ENTRY:  if (wake_rise)      state_d = ST_IDLE;
                       else if (entry_tc)  state_d = ST_DOWN;
            ST_DOWN:   if (wake_rise)      state_d = ST_SETTLE;
            ST_SETTLE: if (settle_tc)      state_d = ST_IRQ;
            ST_IRQ:    if (ack_wr)         state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pd_req   = (state_q == ST_ENTRY) || (state_q == ST_DOWN);
        pd_out   = (state_q == ST_DOWN);
        wake_irq = (state_q == ST_IRQ);
        usr_int  = (usr_src == SRC_HIGH) ?  usr_pin :
                   (usr_src == SRC_LOW)  ? ~usr_pin : 1'b0;
        int0_out = sel_q ? wake_irq : usr_int;
    end
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
    parameter int ENTRY_CYC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_req,
    input logic       pd_out,
    input logic       wake_irq,
    input logic       sel_q,
    input logic [2:0] usr_src,
    input logic       int0_out
);
    logic [15:0] entry_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            entry_run <= '0;
        else if (pd_req && !pd_out)
            entry_run <= (entry_run == 16'hFFFF) ? entry_run : entry_run + 1'b1;
        else
            entry_run <= '0;
    end

    assert_entry_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_out) |-> (entry_run == 16'(ENTRY_CYC)));

    assert_out_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_out |-> pd_req);

    assert_wake_clears_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_out) |-> !pd_req);

    assert_irq_after_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq) |-> (!pd_out && !pd_req));

    assert_usr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && usr_src != 3'd4 && usr_src != 3'd6) |-> !int0_out);
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.ENTRY_CYC(ENTRY_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_req   (pd_req),
    .pd_out   (pd_out),
    .wake_irq (wake_irq),
    .sel_q    (sel_q),
    .usr_src  (usr_src),
    .int0_out (int0_out)
);

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] wake_in = '0;
    logic       usr_pin = 1'b0;
    logic [2:0] usr_src = '0;
    logic       pd_req, pd_out, int0_out;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    pwrdn_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_in(wake_in), .usr_pin(usr_pin),
        .usr_src(usr_src), .pd_req(pd_req), .pd_out(pd_out), .int0_out(int0_out)
    );

    // {sel, src[2:0], pin, expected int0}
    localparam logic [5:0] MUX_VEC [8] = '{
        {1'b0, 3'd4, 1'b1, 1'b1},
        {1'b0, 3'd4, 1'b0, 1'b0},
        {1'b0, 3'd6, 1'b0, 1'b1},
        {1'b0, 3'd6, 1'b1, 1'b0},
        {1'b0, 3'd5, 1'b1, 1'b0},
        {1'b0, 3'd0, 1'b1, 1'b0},
        {1'b1, 3'd4, 1'b1, 1'b0},
        {1'b1, 3'd6, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 pd_req", pd_req, 1'b0);
        check("R1 pd_out", pd_out, 1'b0);
        check("R1 int0", int0_out, 1'b0);
        rst_n = 1'b1;
        tick(2);
        check("R1 pd_out after release", pd_out, 1'b0);

        // R9 mux table
        for (int i = 0; i < 8; i++) begin
            write(2'd1, {MUX_VEC[i][5], 7'd0});
            usr_src = MUX_VEC[i][4:2];
            usr_pin = MUX_VEC[i][1];
            tick(1);
            check("R9 mux", int0_out, MUX_VEC[i][0]);
        end
        usr_src = 3'd0; usr_pin = 1'b0;
        write(2'd1, 8'h80);

        // R7 wake in IDLE
        wake_in[2] = 1'b1; tick(4); wake_in[2] = 1'b0;
        tick(600);
        check("R7 idle wake ignored", int0_out, 1'b0);
        check("R7 no req", pd_req, 1'b0);

        // R2 entry timing
        write(2'd0, 8'h80);
        check("R2 req set", pd_req, 1'b1);
        tick(31);
        check("R2 out low at 31", pd_out, 1'b0);
        tick(1);
        check("R2 out high at 32", pd_out, 1'b1);

        // R3 wake clears after sync
        wake_in[0] = 1'b1;
        tick(2);
        check("R3 still down before e+2", pd_out, 1'b1);
        tick(1);
        check("R3 out cleared", pd_out, 1'b0);
        check("R3 req cleared", pd_req, 1'b0);

        // R10 request during SETTLE ignored
        write(2'd0, 8'h80);
        check("R10 req ignored in settle", pd_req, 1'b0);

        // R4 interrupt delay (1 cycle used by write)
        tick(510);
        check("R4 irq low at 511", int0_out, 1'b0);
        tick(1);
        check("R4 irq high at 512", int0_out, 1'b1);

        // R10 request during IRQ ignored
        write(2'd0, 8'h80);
        check("R10 req ignored in irq", pd_req, 1'b0);

        // R5 acknowledge
        write(2'd2, 8'h00);
        check("R5 irq held on bit0=0", int0_out, 1'b1);
        write(2'd2, 8'h01);
        check("R5 irq cleared", int0_out, 1'b0);
        tick(600);
        check("R5 stays cleared", int0_out, 1'b0);

        // R8 held level does not retrigger
        write(2'd0, 8'h80);
        tick(32);
        check("R8 entry completes with level high", pd_out, 1'b1);
        wake_in[0] = 1'b0;
        tick(5);
        check("R8 fall does not wake", pd_out, 1'b1);
        wake_in[3] = 1'b1; tick(3); wake_in[3] = 1'b0;
        check("R3 other input wakes", pd_out, 1'b0);
        tick(520);
        check("R4 second irq", int0_out, 1'b1);
        write(2'd2, 8'h01);

        // R6 cancel during entry
        write(2'd0, 8'h80);
        tick(5);
        wake_in[1] = 1'b1;
        tick(3);
        check("R6 req cancelled", pd_req, 1'b0);
        wake_in[1] = 1'b0;
        tick(40);
        check("R6 out never set", pd_out, 1'b0);
        tick(560);
        check("R6 no irq", int0_out, 1'b0);

        // R1 reset mid-sequence
        write(2'd0, 8'h80);
        tick(33);
        rst_n = 1'b0;
        tick(1);
        check("R1 reset clears out", pd_out, 1'b0);
        check("R1 reset clears sel", int0_out, 1'b0);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule